// File: doc/BRIEF.md
# Prioritized Interrupt Controller with End-of-Interrupt Modes

This block collects sixteen interrupt channels and raises a single request to a processor. A rising edge on a channel input latches a pending bit. Among the pending channels that are both enabled and unmasked, the one with the highest index wins. When the processor strobes acknowledge, the controller returns an 8-bit vector. The vector is built from a software-programmed base nibble and the 4-bit number of the winning channel. The pending bit of the winning channel clears in the same cycle.

A mode bit in the vector register picks one of two ways of ending an interrupt:

- **Automatic mode** keeps no history of serviced interrupts. Any later pending channel raises the request again straight away.
- **Software mode** sets an in-service bit for the acknowledged channel. While that bit is set, it blocks the channel itself and every lower channel, and higher channels can still preempt it. Software ends the service by writing a zero to the in-service bit.

With every mask bit at zero, the block serves as a polled source: pending bits gather, software reads them and clears them, and no request or in-service state is ever produced.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `vector_valid_o` is 0.
- R2: A 0-to-1 transition on `chan_i[n]` sets pending bit n when enable bit n is 1. It sets nothing when enable bit n is 0. A level held high does not set the bit again after it has been cleared.
- R3: Register addresses: pending 0/1, enable 2/3, mask 4/5, in-service 6/7, vector 8. The lower address of each pair holds channels 0-7 in bits 0-7. The higher address holds channels 8-15. The vector register holds the base in bits 7:4 and the mode bit in bit 3, and reads back as {base, mode, 3'b000}.
- R4: A write to a pending register clears each bit written 0 and keeps each bit written 1. The other bank is not affected.
- R5: `irq_o` is 1 exactly when some channel is pending, enabled, unmasked and not blocked by an in-service bit.
- R6: An `iack_i` strobe while `irq_o` is 1 makes `vector_valid_o` 1 in the next cycle. At that point `vector_o` = {base, index of the highest eligible channel}. `vector_valid_o` is never 1 except in the cycle after a strobe.
- R7: On acknowledge, the pending bit of the winning channel is cleared in both modes.
- R8: With mode bit 0, all in-service bits stay 0. Any channels still eligible keep `irq_o` at 1 after an acknowledge.
- R9: With mode bit 1, the acknowledge sets the winner's in-service bit.
- R10: With mode bit 1, a set in-service bit k blocks channels 0..k from requesting and from being acknowledged. Channels above k still request and are acknowledged.
- R11: A channel blocked by an in-service bit still latches its pending bit. It requests once the blocking bit is cleared.
- R12: A write to an in-service register clears each bit written 0 and keeps each bit written 1. No write ever sets an in-service bit.
- R13: With all mask bits 0, `irq_o` stays 0 and a strobe produces no vector. Pending bits still gather and no in-service bit is set.
- R14: Writing mode bit 0 clears every in-service bit by the second cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_i | input | 16 | Channel request lines, edge sensitive |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for the current address |
| irq_o | output | 1 | Interrupt request to the processor |
| iack_i | input | 1 | One-cycle interrupt acknowledge strobe |
| vector_o | output | 8 | Vector number of the acknowledged channel |
| vector_valid_o | output | 1 | Vector valid, one cycle after an accepted acknowledge |

## Verification

**Assumptions about inputs.** The assertions take the channel lines and the register bus as synchronous to `clk`. They take `iack_i` as a single-cycle strobe.

**Same-cycle collisions.** The assertion on pending clearing excuses a new edge on the acknowledged channel in the same cycle. The assertion on in-service bits excuses only the acknowledge cycle itself.

**How the stimulus keeps within this.** The bench drives every input half a cycle away from the sampling edge. It never pulses a channel in the cycle of its own acknowledge. It changes the mode bit only while no acknowledge is in flight.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned RA_PEND = 0;
  localparam int unsigned RA_EN   = 2;
  localparam int unsigned RA_MASK = 4;
  localparam int unsigned RA_INSV = 6;
  localparam int unsigned RA_VEC  = 8;
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] keep_i,
  input  logic [NCH-1:0] ack_clr_i,
  output logic [NCH-1:0] pend_o
);
  logic [NCH-1:0] chan_q, pend_q, pend_d, rise;
  logic           pend_upd;

  always_comb begin
    rise     = chan_i & ~chan_q & en_i;
    pend_d   = (pend_q & keep_i & ~ack_clr_i) | rise;
    pend_upd = (~&keep_i) | (|ack_clr_i) | (|rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      pend_q <= '0;
    end else begin
      chan_q <= chan_i;
      if (pend_upd) pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R7
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_clr_i != '0) && ((rise & ack_clr_i) == '0)) |=> ((pend_q & $past(ack_clr_i)) == '0));
  // R7
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack_clr_i));
endmodule

// File: rtl/irq_insv_track.sv
module irq_insv_track #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_mode_i,
  input  logic [NCH-1:0] keep_i,
  input  logic [NCH-1:0] set_i,
  output logic [NCH-1:0] insv_o
);
  logic [NCH-1:0] insv_q, insv_d;
  logic           insv_upd;

  always_comb begin
    insv_d   = sw_mode_i ? ((insv_q & keep_i) | set_i) : '0;
    insv_upd = (insv_d != insv_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        insv_q <= '0;
    else if (insv_upd) insv_q <= insv_d;
  end

  assign insv_o = insv_q;

  // R8
  auto_mode_no_insv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_mode_i |=> (insv_q == '0));
  // R12
  insv_set_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((insv_q & ~$past(insv_q)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pend_i,
  input  logic [NCH-1:0]   en_i,
  input  logic [NCH-1:0]   mask_i,
  input  logic [NCH-1:0]   insv_i,
  output logic             req_o,
  output logic [IDX_W-1:0] win_o,
  output logic [NCH-1:0]   win_oh_o
);
  logic [NCH-1:0] blk, elig;

  // blk[i] is set when any in-service bit at i or above is set
  always_comb begin
    logic above;
    above = 1'b0;
    blk   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      above  = above | insv_i[i];
      blk[i] = above;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = pend_i[g] & en_i[g] & mask_i[g] & ~blk[g];
  end

  always_comb begin
    logic seen;
    seen     = 1'b0;
    win_o    = '0;
    win_oh_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i] && !seen) begin
        seen        = 1'b1;
        win_o       = IDX_W'(i);
        win_oh_o[i] = 1'b1;
      end
    end
  end

  assign req_o = |elig;

  // R10
  winner_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ((insv_i >> win_o) == '0));
  // R6
  winner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> $onehot(win_oh_o));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned BANK_W = 8,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BANK_W-1:0] bus_wdata_i,
  output logic [BANK_W-1:0] bus_rdata_o,
  output logic              irq_o,
  input  logic              iack_i,
  output logic [VEC_W-1:0]  vector_o,
  output logic              vector_valid_o
);
  localparam int unsigned NBANK  = NCH / BANK_W;
  localparam int unsigned IDX_W  = $clog2(NCH);
  localparam int unsigned BASE_W = VEC_W - IDX_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // register bank decode
  logic [NBANK-1:0] hit_pend, hit_en, hit_mask, hit_insv;
  logic [NCH-1:0]   pend_keep, insv_keep, en_q, en_d, mask_q, mask_d;
  logic [NCH-1:0]   pend, insv, win_oh, ack_clr, insv_set;
  logic             en_we, mask_we, vec_we, req, ack_fire;
  logic [IDX_W-1:0] win;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_W;
    assign hit_pend[b] = bus_we_i && (bus_addr_i == ADDR_W'(RA_PEND + b));
    assign hit_en[b]   = bus_we_i && (bus_addr_i == ADDR_W'(RA_EN + b));
    assign hit_mask[b] = bus_we_i && (bus_addr_i == ADDR_W'(RA_MASK + b));
    assign hit_insv[b] = bus_we_i && (bus_addr_i == ADDR_W'(RA_INSV + b));
    assign pend_keep[LO +: BANK_W] = hit_pend[b] ? bus_wdata_i : '1;
    assign insv_keep[LO +: BANK_W] = hit_insv[b] ? bus_wdata_i : '1;
    assign en_d[LO +: BANK_W]      = hit_en[b]   ? bus_wdata_i : en_q[LO +: BANK_W];
    assign mask_d[LO +: BANK_W]    = hit_mask[b] ? bus_wdata_i : mask_q[LO +: BANK_W];
  end

  assign en_we   = |hit_en;
  assign mask_we = |hit_mask;
  assign vec_we  = bus_we_i && (bus_addr_i == ADDR_W'(RA_VEC));

  // vector register: base and end-of-interrupt mode
  logic [BASE_W-1:0] base_q, base_d;
  logic              sw_mode_q, sw_mode_d;
  logic [IDX_W-2:0]  unused_wdata;
  assign base_d       = bus_wdata_i[VEC_W-1:IDX_W];
  assign sw_mode_d    = bus_wdata_i[IDX_W-1];
  assign unused_wdata = bus_wdata_i[IDX_W-2:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q      <= '0;
      mask_q    <= '0;
      base_q    <= '0;
      sw_mode_q <= 1'b0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (mask_we) mask_q <= mask_d;
      if (vec_we) begin
        base_q    <= base_d;
        sw_mode_q <= sw_mode_d;
      end
    end
  end

  // acknowledge
  assign ack_fire = iack_i & req;
  assign ack_clr  = ack_fire ? win_oh : '0;
  assign insv_set = (ack_fire && sw_mode_q) ? win_oh : '0;

  irq_pend_capture #(.NCH(NCH)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .chan_i(chan_i), .en_i(en_q),
    .keep_i(pend_keep), .ack_clr_i(ack_clr), .pend_o(pend)
  );

  irq_insv_track #(.NCH(NCH)) u_insv (
    .clk(clk), .rst_n(rst_sync_n), .sw_mode_i(sw_mode_q),
    .keep_i(insv_keep), .set_i(insv_set), .insv_o(insv)
  );

  irq_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_sync_n), .pend_i(pend), .en_i(en_q), .mask_i(mask_q),
    .insv_i(insv), .req_o(req), .win_o(win), .win_oh_o(win_oh)
  );

  assign irq_o = req;

  // vector output: next-state and register
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vv_q, vv_d;
  always_comb begin
    vv_d  = ack_fire;
    vec_d = ack_fire ? {base_q, win} : vec_q;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vec_q <= '0;
      vv_q  <= 1'b0;
    end else begin
      vv_q <= vv_d;
      if (ack_fire) vec_q <= vec_d;
    end
  end
  assign vector_o       = vec_q;
  assign vector_valid_o = vv_q;

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < int'(NBANK); b++) begin
      if (bus_addr_i == ADDR_W'(RA_PEND + b)) bus_rdata_o = pend[b*BANK_W +: BANK_W];
      if (bus_addr_i == ADDR_W'(RA_EN + b))   bus_rdata_o = en_q[b*BANK_W +: BANK_W];
      if (bus_addr_i == ADDR_W'(RA_MASK + b)) bus_rdata_o = mask_q[b*BANK_W +: BANK_W];
      if (bus_addr_i == ADDR_W'(RA_INSV + b)) bus_rdata_o = insv[b*BANK_W +: BANK_W];
    end
    if (bus_addr_i == ADDR_W'(RA_VEC))
      bus_rdata_o = BANK_W'({base_q, sw_mode_q, {(IDX_W-1){1'b0}}});
  end

  // R6
  valid_after_iack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vector_valid_o |-> $past(iack_i));
  // R13
  masked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] chan;
  logic [3:0]  addr;
  logic        we;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        irq, iack, vv;
  logic [7:0]  vec;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .chan_i(chan), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .iack_i(iack),
    .vector_o(vec), .vector_valid_o(vv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 4'(a);
    #0.5;
    d = int'(rdata);
  endtask

  task automatic rd16(input int a, output int d);
    int lo, hi;
    rd(a, lo); rd(a + 1, hi);
    d = (hi << 8) | lo;
  endtask

  task automatic pulse(input int m);
    @(negedge clk); chan = 16'(m);
    @(negedge clk); chan = '0;
  endtask

  task automatic ack(output int valid, output int v);
    @(negedge clk); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
    valid = int'(vv); v = int'(vec);
  endtask

  task automatic clear_all();
    wr(6, 0); wr(7, 0); wr(0, 0); wr(1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, valid, v, pat, exp_hi;
    rst_n = 1'b0; chan = '0; addr = '0; we = 1'b0; wdata = '0; iack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R3 address map
    for (int a = 0; a <= 8; a++) begin
      rd(a, d); chk($sformatf("R1 reset reg %0d", a), d, 0);
    end
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 vector_valid after reset", int'(vv), 0);

    // R3 read-back of enable, mask and vector registers
    wr(2, 8'h5A); wr(3, 8'hC3); wr(4, 8'h0F); wr(5, 8'hF0); wr(8, 8'hAF);
    rd(2, d); chk("R3 enable A", d, 8'h5A);
    rd(3, d); chk("R3 enable B", d, 8'hC3);
    rd(4, d); chk("R3 mask A", d, 8'h0F);
    rd(5, d); chk("R3 mask B", d, 8'hF0);
    rd(8, d); chk("R3 vector reg", d, 8'hA8);

    wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF); wr(8, 8'hA0);

    // R2 edge capture sweep
    for (int ch = 0; ch < 16; ch++) begin
      pulse(1 << ch);
      rd16(0, d); chk($sformatf("R2 capture ch%0d", ch), d, 1 << ch);
      wr(0, 0); wr(1, 0);
    end
    wr(2, 8'h00);
    pulse(16'hFFFF);
    rd16(0, d); chk("R2 enable-0 bank A ignored", d, 16'hFF00);
    wr(1, 0); wr(2, 8'hFF);
    @(negedge clk); chan = 16'h0004;
    @(negedge clk);
    wr(0, 0);
    repeat (2) @(negedge clk);
    rd16(0, d); chk("R2 held level no retrigger", d, 0);
    chan = '0;

    // R4 pending write-zero-clear
    pulse(16'hFFFF);
    wr(0, 8'hF0);
    rd16(0, d); chk("R4 pending clear rule", d, 16'hFFF0);
    wr(0, 0); wr(1, 0);

    // R5 R6 R7 R8 priority sweep in automatic mode
    for (int k = 0; k < 16; k++) begin
      pat = (1 << k) | (((k * 5) + 3) & ((1 << k) - 1));
      pulse(pat);
      chk($sformatf("R5 irq pattern %0h", pat), int'(irq), 1);
      ack(valid, v);
      chk($sformatf("R6 valid k=%0d", k), valid, 1);
      chk($sformatf("R6 vector k=%0d", k), v, 8'hA0 | k);
      rd16(0, d); chk($sformatf("R7 pending after ack k=%0d", k), d, pat & ~(1 << k));
      rd16(6, d); chk($sformatf("R8 insv zero k=%0d", k), d, 0);
      chk($sformatf("R8 irq remains k=%0d", k), int'(irq), ((pat & ~(1 << k)) != 0) ? 1 : 0);
      wr(0, 0); wr(1, 0);
    end

    // R8 drain in priority order
    pulse(16'h8421);
    for (int i = 3; i >= 0; i--) begin
      ack(valid, v);
      chk($sformatf("R8 drain step %0d", i), v, 8'hA0 | (i * 5));
    end
    ack(valid, v);
    chk("R6 no vector when idle", valid, 0);
    chk("R5 irq low when drained", int'(irq), 0);

    // R9 R10 R11 R12 software mode
    wr(8, 8'hA8);
    pulse(1 << 3);
    ack(valid, v); chk("R9 ack ch3", v, 8'hA3);
    rd(6, d); chk("R9 insv set ch3", d, 8'h08);
    pulse(1 << 1);
    chk("R10 lower blocked irq", int'(irq), 0);
    ack(valid, v); chk("R10 lower blocked no vector", valid, 0);
    rd(0, d); chk("R11 lower still pends", d, 8'h02);
    pulse(1 << 3);
    rd(0, d); chk("R11 own channel pends", d, 8'h0A);
    chk("R11 own channel no irq", int'(irq), 0);
    pulse(1 << 12);
    chk("R10 higher requests", int'(irq), 1);
    ack(valid, v); chk("R10 higher acked", v, 8'hAC);
    rd(7, d); chk("R9 insv set ch12", d, 8'h10);
    wr(7, 8'hEF);
    rd(7, d); chk("R12 clear ch12", d, 0);
    wr(6, 8'hFF);
    rd(6, d); chk("R12 write ones keeps", d, 8'h08);
    chk("R10 still blocked by ch3", int'(irq), 0);
    wr(6, 8'hF7);
    rd(6, d); chk("R12 clear ch3", d, 0);
    chk("R11 request after clear", int'(irq), 1);
    ack(valid, v); chk("R11 ch3 acked", v, 8'hA3);
    wr(6, 8'hF7);
    ack(valid, v); chk("R11 ch1 acked", v, 8'hA1);
    rd(6, d); chk("R9 insv ch1", d, 8'h02);
    // R14 mode switch clears in-service
    wr(8, 8'hA0);
    @(negedge clk);
    rd16(6, d); chk("R14 insv cleared on auto", d, 0);

    // R10 pairwise block sweep
    wr(8, 8'hA8);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        if (a != b) begin
          clear_all();
          pulse(1 << a);
          ack(valid, v);
          pulse(1 << b);
          chk($sformatf("R10 insv %0d req %0d irq", a, b), int'(irq), (b > a) ? 1 : 0);
          if (b > a) begin
            ack(valid, v);
            chk($sformatf("R10 insv %0d preempt %0d", a, b), v, 8'hA0 | b);
          end
        end
      end
    end
    clear_all();

    // R13 polled mode
    wr(4, 0); wr(5, 0);
    pulse(16'h81FF);
    chk("R13 polled no irq", int'(irq), 0);
    ack(valid, v); chk("R13 polled no vector", valid, 0);
    rd16(0, d); chk("R13 pending gathers", d, 16'h81FF);
    rd16(6, d); chk("R13 no insv", d, 0);
    wr(1, 8'h7F);
    rd16(0, d); exp_hi = 16'h01FF; chk("R13 polled clear", d, exp_hi);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule